// File: doc/BRIEF.md
# Latency-Hiding Warp Scheduler

This block tracks up to 64 resident warps (groups of 32 threads) and, every clock, issues one warp that is able to run. A warp that has sent a long-latency memory request is parked by a stall event and skipped until a wake event for it comes back. Issue moves on to the other warps in the meantime, so memory latency is hidden behind useful work. Ready warps are served round-robin, starting just after the warp issued last.

Work arrives as thread-block launches, each giving a thread count. A legal count is a non-zero multiple of 32 and at most 1024, so a block holds 1 to 32 warps. A legal block is admitted as a whole only when enough free warp slots exist for all of its warps. It takes the lowest-numbered free slots. Until then the launch is left pending and the requester keeps it asserted. When every warp of a block has reported finished, all of that block's slots are released together.

Top module: `warp_sched`

## Requirements
- R1: During and right after reset, issue_valid and resp_valid are 0 and all 64 warp slots are free.
- R2: A launch whose thread count is 0, is not a multiple of 32, or is above 1024 gets resp_valid=1 with resp_accept=0 on the next clock edge, and no slot is taken.
- R3: A legal launch of T threads, presented while at least T/32 slots are free, gets resp_valid=1 and resp_accept=1 on the next edge. It occupies the T/32 lowest-numbered free slots, and resp_first_warp names the lowest of them.
- R4: A legal launch presented while too few slots are free gets no response while held. It is accepted on the edge after the cycle in which enough slots are free.
- R5: No more than 64 warps are resident: two 1024-thread blocks fill the scheduler, and a further launch waits.
- R6: On each edge, at most one warp is issued. The warp named by issue_warp is the first eligible slot found by searching upward, with wrap-around, from the slot after the warp issued last. After reset the search starts at slot 0.
- R7: A stall for a resident warp, presented in cycle k, keeps that warp out of the issue made at the end of cycle k and out of every later issue until the warp is woken.
- R8: A wake for a parked warp, presented in cycle k, makes it eligible for the issue at the end of cycle k. A wake for a warp that is not parked has no effect.
- R9: A finish for a resident warp, presented in cycle k, removes it from issue from the end of cycle k onward. When the last warp of a block finishes, all of that block's slots become free for admission from the next cycle.
- R10: Stall, wake and finish events that name a free slot are ignored. A block later admitted into that slot starts eligible and with its full warp count.
- R11: When no warp is eligible, issue_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_valid | input | 1 | Block launch request, held until resp_valid |
| launch_threads | input | 12 | Thread count of the requested block |
| stall_valid | input | 1 | Park a warp waiting on memory |
| stall_warp | input | 6 | Slot to park |
| wake_valid | input | 1 | Memory returned for a warp |
| wake_warp | input | 6 | Slot to wake |
| finish_valid | input | 1 | Warp has completed |
| finish_warp | input | 6 | Slot that completed |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_warp | output | 6 | Slot of the issued warp |
| resp_valid | output | 1 | Launch decision present |
| resp_accept | output | 1 | 1 = admitted, 0 = rejected |
| resp_first_warp | output | 6 | Lowest slot given to an admitted block, 0 otherwise |

## Verification
Every result is registered once. The issue choice and the launch decision that depend on inputs presented in cycle k are therefore visible right after the rising edge that closes cycle k. Stall, wake and finish events already shape that same issue. The bench drives inputs on the falling edge and pushes the expected issue and response for the coming edge into a queue. A monitor pops each item one nanosecond after the rising edge and compares it, so every comparison sits exactly one edge after its stimulus. Pending launches are checked as an absence of response on each held cycle, and as an acceptance on the edge that follows the release of enough slots.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    // Slot count must be a power of two so slot arithmetic wraps cleanly.
    parameter int SLOTS             = 64;
    parameter int SLOT_W            = $clog2(SLOTS);
    parameter int WARP_SIZE         = 32;
    parameter int LANE_W            = $clog2(WARP_SIZE);
    parameter int BLOCK_MAX_THREADS = 1024;
    parameter int BLOCK_MAX_WARPS   = BLOCK_MAX_THREADS / WARP_SIZE;
    parameter int THREAD_W          = 12;
    parameter int NWARP_W           = $clog2(BLOCK_MAX_WARPS + 1);

    typedef logic [SLOT_W-1:0]   slot_t;
    typedef logic [NWARP_W-1:0]  nwarp_t;
    typedef logic [THREAD_W-1:0] thr_t;

    // A per-warp event (stall, wake or finish).
    typedef struct packed {
        logic  valid;
        slot_t id;
    } warp_evt_t;

    // State held for each warp slot.
    typedef struct packed {
        logic  busy;
        logic  parked;
        logic  done;
        slot_t owner;   // lowest slot of the block this warp belongs to
    } slot_state_t;

    function automatic logic evt_hits(warp_evt_t e, slot_t w);
        return e.valid && (e.id == w);
    endfunction

endpackage

// File: rtl/warp_sched_admit_check.sv
module warp_sched_admit_check
    import warp_sched_pkg::*;
(
    input  thr_t   threads,
    output logic   legal,
    output nwarp_t nwarps
);
    logic lane_aligned;
    logic in_range;

    assign lane_aligned = (threads[LANE_W-1:0] == '0);
    assign in_range     = (threads != '0) && (threads <= thr_t'(BLOCK_MAX_THREADS));
    assign legal        = lane_aligned && in_range;
    assign nwarps       = legal ? nwarp_t'(threads >> LANE_W) : '0;
endmodule

// File: rtl/warp_sched_alloc.sv
module warp_sched_alloc
    import warp_sched_pkg::*;
(
    input  logic [SLOTS-1:0] free_mask,
    input  nwarp_t           need,
    output logic [SLOTS-1:0] grant_mask,
    output slot_t            first,
    output logic             fits
);
    always_comb begin
        int   taken;
        logic seen;
        taken      = 0;
        seen       = 1'b0;
        grant_mask = '0;
        first      = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (free_mask[i]) begin
                if (!seen) begin
                    first = slot_t'(i);
                    seen  = 1'b1;
                end
                if (taken < int'(need)) begin
                    grant_mask[i] = 1'b1;
                    taken         = taken + 1;
                end
            end
        end
        fits = (need != '0) && (taken == int'(need));
    end
endmodule

// File: rtl/warp_sched_rr.sv
module warp_sched_rr
    import warp_sched_pkg::*;
(
    input  logic [SLOTS-1:0] elig,
    input  slot_t            last,
    output logic             found,
    output slot_t            pick
);
    always_comb begin
        slot_t cand;
        found = 1'b0;
        pick  = last;
        cand  = last;
        for (int i = 1; i <= SLOTS; i++) begin
            cand = last + slot_t'(i);
            if (!found && elig[cand]) begin
                found = 1'b1;
                pick  = cand;
            end
        end
    end
endmodule

// File: rtl/warp_sched.sv
module warp_sched
    import warp_sched_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                launch_valid,
    input  logic [THREAD_W-1:0] launch_threads,
    input  logic                stall_valid,
    input  logic [SLOT_W-1:0]   stall_warp,
    input  logic                wake_valid,
    input  logic [SLOT_W-1:0]   wake_warp,
    input  logic                finish_valid,
    input  logic [SLOT_W-1:0]   finish_warp,
    output logic                issue_valid,
    output logic [SLOT_W-1:0]   issue_warp,
    output logic                resp_valid,
    output logic                resp_accept,
    output logic [SLOT_W-1:0]   resp_first_warp
);
    warp_evt_t   stall_e, wake_e, fin_e;
    slot_state_t st     [SLOTS];
    nwarp_t      remain [SLOTS];

    logic [SLOTS-1:0] busy_vec, free_vec, elig_vec, grant_vec;
    logic   legal, fits, adm_go;
    nwarp_t need;
    slot_t  alloc_first;
    logic   rr_found;
    slot_t  rr_pick;
    logic   fin_ok, release_blk;
    slot_t  fin_owner;

    assign stall_e = '{valid: stall_valid,  id: stall_warp};
    assign wake_e  = '{valid: wake_valid,   id: wake_warp};
    assign fin_e   = '{valid: finish_valid, id: finish_warp};

    // Per-slot eligibility, with same-cycle events folded in.
    generate
        for (genvar w = 0; w < SLOTS; w++) begin : g_slot
            assign busy_vec[w] = st[w].busy;
            assign elig_vec[w] = st[w].busy && !st[w].done
                               && (!st[w].parked || evt_hits(wake_e, slot_t'(w)))
                               && !evt_hits(stall_e, slot_t'(w))
                               && !evt_hits(fin_e, slot_t'(w));
        end
    endgenerate

    assign free_vec = ~busy_vec;

    warp_sched_admit_check i_check (
        .threads (launch_threads),
        .legal   (legal),
        .nwarps  (need)
    );

    warp_sched_alloc i_alloc (
        .free_mask  (free_vec),
        .need       (need),
        .grant_mask (grant_vec),
        .first      (alloc_first),
        .fits       (fits)
    );

    warp_sched_rr i_rr (
        .elig  (elig_vec),
        .last  (issue_warp),
        .found (rr_found),
        .pick  (rr_pick)
    );

    assign adm_go      = launch_valid && legal && fits;
    assign fin_ok      = finish_valid && st[finish_warp].busy && !st[finish_warp].done;
    assign fin_owner   = st[finish_warp].owner;
    assign release_blk = fin_ok && (remain[fin_owner] == nwarp_t'(1));

    // Issue and launch response registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            issue_valid     <= 1'b0;
            issue_warp      <= '1;
            resp_valid      <= 1'b0;
            resp_accept     <= 1'b0;
            resp_first_warp <= '0;
        end else begin
            issue_valid <= rr_found;
            if (rr_found) begin
                issue_warp <= rr_pick;
            end
            resp_valid      <= launch_valid && (!legal || fits);
            resp_accept     <= adm_go;
            resp_first_warp <= adm_go ? alloc_first : '0;
        end
    end

    // Slot state and per-block remaining-warp counters (indexed by lowest slot).
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                st[i]     <= '0;
                remain[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (adm_go && grant_vec[i]) begin
                    st[i] <= '{busy: 1'b1, parked: 1'b0, done: 1'b0, owner: alloc_first};
                end else if (st[i].busy) begin
                    if (release_blk && (st[i].owner == fin_owner)) begin
                        st[i] <= '0;
                    end else begin
                        if (evt_hits(fin_e, slot_t'(i))) begin
                            st[i].done <= 1'b1;
                        end
                        if (evt_hits(stall_e, slot_t'(i))) begin
                            st[i].parked <= 1'b1;
                        end else if (evt_hits(wake_e, slot_t'(i))) begin
                            st[i].parked <= 1'b0;
                        end
                    end
                end
                if (adm_go && (alloc_first == slot_t'(i))) begin
                    remain[i] <= need;
                end else if (fin_ok && (fin_owner == slot_t'(i))) begin
                    remain[i] <= remain[i] - nwarp_t'(1);
                end
            end
        end
    end
endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk
    import warp_sched_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                launch_valid,
    input logic [THREAD_W-1:0] launch_threads,
    input logic                stall_valid,
    input logic [SLOT_W-1:0]   stall_warp,
    input logic                finish_valid,
    input logic [SLOT_W-1:0]   finish_warp,
    input logic                issue_valid,
    input logic [SLOT_W-1:0]   issue_warp,
    input logic                resp_valid,
    input logic                resp_accept,
    input logic [SLOT_W-1:0]   resp_first_warp,
    input logic [SLOTS-1:0]    busy_vec
);
    logic [SLOTS-1:0] busy_prev;
    logic             bad_count;

    always_ff @(posedge clk) begin
        if (rst) busy_prev <= '0;
        else     busy_prev <= busy_vec;
    end

    assign bad_count = (launch_threads == '0)
                     || (launch_threads[LANE_W-1:0] != '0)
                     || (launch_threads > THREAD_W'(BLOCK_MAX_THREADS));

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!issue_valid && !resp_valid && busy_vec == '0)); // R1

    AST_REJECT_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (launch_valid && bad_count) |=> (resp_valid && !resp_accept)); // R2

    AST_ACCEPT_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_accept) |-> (!busy_prev[resp_first_warp] && busy_vec[resp_first_warp])); // R3

    AST_ISSUE_RESIDENT: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> busy_vec[issue_warp]); // R6

    AST_STALL_SKIP: assert property (@(posedge clk) disable iff (rst)
        stall_valid |=> !(issue_valid && issue_warp == $past(stall_warp))); // R7

    AST_FINISH_SKIP: assert property (@(posedge clk) disable iff (rst)
        finish_valid |=> !(issue_valid && issue_warp == $past(finish_warp))); // R9

    AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (busy_vec == '0) |=> !issue_valid); // R11
endmodule

bind warp_sched warp_sched_chk i_chk (
    .clk             (clk),
    .rst             (rst),
    .launch_valid    (launch_valid),
    .launch_threads  (launch_threads),
    .stall_valid     (stall_valid),
    .stall_warp      (stall_warp),
    .finish_valid    (finish_valid),
    .finish_warp     (finish_warp),
    .issue_valid     (issue_valid),
    .issue_warp      (issue_warp),
    .resp_valid      (resp_valid),
    .resp_accept     (resp_accept),
    .resp_first_warp (resp_first_warp),
    .busy_vec        (busy_vec)
);

// File: tb/test_warp_sched.sv
`timescale 1ns/1ps
module test_warp_sched;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        launch_valid = 1'b0;
    logic [11:0] launch_threads = '0;
    logic        stall_valid = 1'b0;
    logic [5:0]  stall_warp = '0;
    logic        wake_valid = 1'b0;
    logic [5:0]  wake_warp = '0;
    logic        finish_valid = 1'b0;
    logic [5:0]  finish_warp = '0;
    logic        issue_valid;
    logic [5:0]  issue_warp;
    logic        resp_valid;
    logic        resp_accept;
    logic [5:0]  resp_first_warp;

    always #5 clk = ~clk;

    warp_sched i_warp_sched (
        .clk (clk), .rst (rst),
        .launch_valid (launch_valid), .launch_threads (launch_threads),
        .stall_valid (stall_valid), .stall_warp (stall_warp),
        .wake_valid (wake_valid), .wake_warp (wake_warp),
        .finish_valid (finish_valid), .finish_warp (finish_warp),
        .issue_valid (issue_valid), .issue_warp (issue_warp),
        .resp_valid (resp_valid), .resp_accept (resp_accept),
        .resp_first_warp (resp_first_warp)
    );

    typedef struct {
        bit    iv;
        int    iw;
        bit    rv;
        bit    ra;
        int    rf;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done_run = 0;

    // Model of the requirements.
    bit m_busy[64], m_park[64], m_done[64];
    int m_owner[64], m_rem[64];
    int m_last = 63;

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: compares one item per edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (issue_valid !== e.iv || (e.iv && int'(issue_warp) != e.iw)) begin
                n_bad++;
                $display("FAIL %s issue: got v=%0b w=%0d expected v=%0b w=%0d",
                         e.tag, issue_valid, issue_warp, e.iv, e.iw);
            end
            n_cmp++;
            if (resp_valid !== e.rv || (e.rv && (resp_accept !== e.ra || int'(resp_first_warp) != e.rf))) begin
                n_bad++;
                $display("FAIL %s resp: got v=%0b a=%0b f=%0d expected v=%0b a=%0b f=%0d",
                         e.tag, resp_valid, resp_accept, resp_first_warp, e.rv, e.ra, e.rf);
            end
        end
    end

    // Driver: predicts the coming edge, pushes it, then advances one cycle.
    task automatic cycle(string tag);
        exp_t e;
        bit   elig[64];
        int   grant[$];
        e.iv = 0; e.iw = 0; e.rv = 0; e.ra = 0; e.rf = 0; e.tag = tag;
        for (int w = 0; w < 64; w++) begin
            elig[w] = m_busy[w] && !m_done[w]
                      && (!m_park[w] || (wake_valid && int'(wake_warp) == w))
                      && !(stall_valid && int'(stall_warp) == w)
                      && !(finish_valid && int'(finish_warp) == w);
        end
        for (int i = 1; i <= 64; i++) begin
            int c;
            c = (m_last + i) % 64;
            if (!e.iv && elig[c]) begin e.iv = 1; e.iw = c; end
        end
        if (launch_valid) begin
            int t;
            t = int'(launch_threads);
            if (t == 0 || t % 32 != 0 || t > 1024) begin
                e.rv = 1; e.ra = 0;
            end else begin
                for (int w = 0; w < 64; w++)
                    if (!m_busy[w] && grant.size() < t / 32) grant.push_back(w);
                if (grant.size() == t / 32) begin
                    e.rv = 1; e.ra = 1; e.rf = grant[0];
                end else grant.delete();
            end
        end
        q.push_back(e);
        // State update from old state; admission list was taken before it.
        if (e.iv) m_last = e.iw;
        if (stall_valid && m_busy[stall_warp]) m_park[stall_warp] = 1;
        else if (wake_valid && m_busy[wake_warp]) m_park[wake_warp] = 0;
        if (finish_valid && m_busy[finish_warp] && !m_done[finish_warp]) begin
            int o;
            o = m_owner[finish_warp];
            m_done[finish_warp] = 1;
            m_rem[o]--;
            if (m_rem[o] == 0)
                for (int w = 0; w < 64; w++)
                    if (m_busy[w] && m_owner[w] == o) begin
                        m_busy[w] = 0; m_done[w] = 0; m_park[w] = 0;
                    end
        end
        if (e.ra) begin
            foreach (grant[k]) begin
                m_busy[grant[k]] = 1; m_park[grant[k]] = 0;
                m_done[grant[k]] = 0; m_owner[grant[k]] = grant[0];
            end
            m_rem[grant[0]] = grant.size();
        end
        @(negedge clk);
        stall_valid = 0; wake_valid = 0; finish_valid = 0;
        if (e.rv) launch_valid = 0;
    endtask

    task automatic launch(int t);
        launch_valid = 1; launch_threads = 12'(t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state observed directly.
        n_cmp++;
        if (issue_valid !== 1'b0 || resp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got iv=%0b rv=%0b expected 0 0", issue_valid, resp_valid);
        end
        rst = 0;
        repeat (3) cycle("R1/R11 idle after reset");

        // R2: illegal counts.
        launch(0);    cycle("R2 zero threads");
        launch(48);   cycle("R2 not multiple of 32");
        launch(1056); cycle("R2 above 1024");
        launch(4064); cycle("R2 far above 1024");
        cycle("R2 no slot taken");

        // R3, R6: first block and round-robin order.
        launch(1024); cycle("R3 accept 1024");
        repeat (5) cycle("R6 round robin");
        launch(1024); cycle("R5 second 1024 fills slots");
        repeat (3) cycle("R6 round robin");

        // R4, R5: pending launch with slots full.
        launch(64);
        repeat (4) cycle("R4/R5 pending no response");

        // R7: stall the warp that would issue next, then the one after.
        stall_valid = 1; stall_warp = 6'((m_last + 1) % 64); cycle("R7 stall skipped");
        repeat (3) cycle("R7 parked warp skipped");
        stall_valid = 1; stall_warp = 6'((m_last + 1) % 64); cycle("R7 second stall");
        repeat (2) cycle("R7 parked");

        // R8: wake a parked warp and a non-parked warp.
        wake_valid = 1; wake_warp = stall_warp; cycle("R8 wake");
        wake_valid = 1; wake_warp = 6'((m_last + 1) % 64); cycle("R8 wake of ready warp no effect");
        repeat (70) cycle("R8 woken warp served in rotation");

        // R9, R4: finish block 0, pending 64-thread launch then admitted.
        for (int w = 0; w < 32; w++) begin
            finish_valid = 1; finish_warp = 6'(w);
            cycle("R9/R4 finish block0 warp");
        end
        repeat (3) cycle("R9 freed warps not issued");

        // R10: events on free slots ignored.
        stall_valid = 1; stall_warp = 6'd5; cycle("R10 stall free slot");
        finish_valid = 1; finish_warp = 6'd9; cycle("R10 finish free slot");
        wake_valid = 1; wake_warp = 6'd20; cycle("R10 wake free slot");
        launch(256); cycle("R10/R3 admit into slots after ignored events");
        repeat (70) cycle("R10 new block runs");
        finish_valid = 1; finish_warp = 6'd9; cycle("R10 finish counts once");
        repeat (3) cycle("R10 rotation");

        // R11: park all resident warps, then drain everything.
        for (int w = 0; w < 64; w++) begin
            if (m_busy[w] && !m_park[w] && !m_done[w]) begin
                stall_valid = 1; stall_warp = 6'(w); cycle("R11 park all");
            end
        end
        repeat (3) cycle("R11 all parked no issue");
        for (int w = 0; w < 64; w++) begin
            if (m_busy[w] && !m_done[w]) begin
                finish_valid = 1; finish_warp = 6'(w); cycle("R9/R11 drain");
            end
        end
        repeat (3) cycle("R11 empty no issue");
        launch(1024); cycle("R9 slots reusable after drain");
        repeat (3) cycle("R6 rotation after reuse");

        @(negedge clk);
        done_run = 1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_run) begin
            n_bad++;
            $display("FAIL watchdog: got no completion expected completion");
            report();
            $finish;
        end
    end
endmodule